// File: doc/BRIEF.md
# Rounding Vector Shifter

This block is a SIMD datapath stage. It shifts every element of a data vector by its own signed amount. Each amount comes from the least significant byte of the matching element of a companion shift vector. A positive amount shifts left. A negative amount shifts right by its magnitude and rounds to nearest instead of truncating. Any other bits of the companion element have no effect.

The element size can be 8, 16, 32 or 64 bits. The elements can be signed or unsigned. The vector can be 64 or 128 bits wide. The caller presents both vectors with the three mode selects and pulses `in_valid`. On the next clock edge the block registers the result and raises `out_valid`. The registered result then holds until the next strobe.

A two-state controller drives `out_valid`:
- `ST_IDLE` means no fresh result is present. It moves to `ST_EMIT` on `in_valid`.
- `ST_EMIT` marks the cycle that carries a new result. It stays in `ST_EMIT` if `in_valid` is high again, and returns to `ST_IDLE` otherwise.

Top module: `rvs_shifter`

## Requirements
- R1: Each lane's shift amount is the least significant byte of the matching shift element, read as a two's-complement value from -128 to 127. Any bits above that byte are ignored.
- R2: A positive amount smaller than the element width shifts the element left. Bits that leave the lane are discarded, with no saturation.
- R3: A positive amount equal to or larger than the element width yields zero.
- R4: A negative amount -n (with n no larger than the element width) yields the value (element + 2^(n-1)) shifted right by n. The sum is taken one bit wider than the element, so any carry is kept.
- R5: With `is_unsigned`=0, elements are signed and right shifts copy the sign bit. With `is_unsigned`=1, elements are unsigned and right shifts fill with zeros.
- R6: A negative amount whose magnitude exceeds the element width yields zero. At a magnitude exactly equal to the width, the R4 rule applies: an unsigned element with its top bit set gives 1.
- R7: An amount of zero passes the element through unchanged.
- R8: `size_code` selects the element size: 00 gives 8-bit, 01 gives 16-bit, 10 gives 32-bit and 11 gives 64-bit lanes. Lane i occupies bits [i*size +: size] of both vectors.
- R9: With `wide`=0, the vector is 64 bits. Result bits 127:64 are zero, and input bits 127:64 have no effect.
- R10: `result` and `out_valid` change on the clock edge that samples `in_valid`=1. `out_valid` is high for exactly the cycles that follow a strobe. `result` holds its value when no strobe arrives.
- R11: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: present operands are captured |
| size_code | input | 2 | Element size select |
| is_unsigned | input | 1 | 1 = unsigned elements, 0 = signed |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| data_a | input | 128 | Data vector |
| shift_b | input | 128 | Per-lane shift-amount vector |
| out_valid | output | 1 | High in the cycle after a strobe |
| result | output | 128 | Registered shifted vector |

## Verification
The bench builds the block with its default 128-bit maximum vector width. Within one build, that reaches all four element sizes, both signednesses and both vector widths. Directed vectors cover the hand-worked corners:
- carry out of the rounding sum in a 32-bit lane;
- a shift by exactly the lane width;
- amounts of -128, +8 and +127;
- upper control bits that must be ignored.

Random traffic with gaps and back-to-back strobes is then compared on every cycle against a wide-integer reference model.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } elem_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;

    localparam int NUM_SIZES = 4;
    localparam int MIN_ELEM_W = 8;
    localparam int AMT_W = 8;

endpackage

// File: rtl/rvs_lane.sv
module rvs_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] ctl,
    input  logic         uns,
    output logic [W-1:0] y
);
    localparam int EW = W + 1;

    logic [7:0]    amt;
    logic [7:0]    mag;
    logic [EW-1:0] ext;
    logic [EW-1:0] bias;
    logic [EW-1:0] sum;
    logic [EW-1:0] shr;

    assign amt = ctl[7:0];

    generate
        if (W > 8) begin : g_hi
            logic unused_ctl_hi;
            assign unused_ctl_hi = ^ctl[W-1:8];
        end
    endgenerate

    always_comb begin
        mag  = 8'd0 - amt;
        ext  = {(~uns & x[W-1]), x};
        bias = '0;
        sum  = '0;
        shr  = '0;
        y    = x;
        if (amt == 8'd0) begin
            y = x;
        end else if (!amt[7]) begin
            if ({24'd0, amt} >= 32'(W)) y = '0;
            else                        y = x << amt;
        end else begin
            if ({24'd0, mag} > 32'(W)) begin
                y = '0;
            end else begin
                bias = EW'(1) << (mag - 8'd1);
                sum  = ext + bias;
                if (uns) shr = sum >> mag;
                else     shr = EW'($signed(sum) >>> mag);
                y = shr[W-1:0];
            end
        end
    end
endmodule

// File: rtl/rvs_bank.sv
module rvs_bank #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             uns,
    output logic [VEC_W-1:0] y
);
    localparam int NUM_LANES = VEC_W / ELEM_W;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            rvs_lane #(.W(ELEM_W)) u_lane (
                .x   (a[i*ELEM_W +: ELEM_W]),
                .ctl (b[i*ELEM_W +: ELEM_W]),
                .uns (uns),
                .y   (y[i*ELEM_W +: ELEM_W])
            );
        end
    endgenerate
endmodule

// File: rtl/rvs_shifter.sv
module rvs_shifter
    import rvs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       size_code,
    input  logic             is_unsigned,
    input  logic             wide,
    input  logic [VEC_W-1:0] data_a,
    input  logic [VEC_W-1:0] shift_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    localparam int HALF_W = VEC_W / 2;

    ctl_state_e       st_q, st_nxt;
    logic [VEC_W-1:0] bank_y [NUM_SIZES];
    logic [VEC_W-1:0] sel_y;
    logic [VEC_W-1:0] nxt_y;
    logic [VEC_W-1:0] result_q;

    generate
        for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
            rvs_bank #(.VEC_W(VEC_W), .ELEM_W(MIN_ELEM_W << g)) u_bank (
                .a   (data_a),
                .b   (shift_b),
                .uns (is_unsigned),
                .y   (bank_y[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (elem_size_e'(size_code))
            ESZ_8:   sel_y = bank_y[0];
            ESZ_16:  sel_y = bank_y[1];
            ESZ_32:  sel_y = bank_y[2];
            ESZ_64:  sel_y = bank_y[3];
            default: sel_y = '0;
        endcase
        nxt_y = sel_y;
        if (!wide) nxt_y[VEC_W-1:HALF_W] = '0;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_nxt = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_nxt = in_valid ? ST_EMIT : ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= nxt_y;
    end

    assign out_valid = (st_q == ST_EMIT);
    assign result    = result_q;
endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             wide,
    input logic [VEC_W-1:0] data_a,
    input logic [VEC_W-1:0] shift_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    localparam int HALF_W = VEC_W / 2;

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[VEC_W-1:HALF_W] == '0)); // R9
    AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && shift_b == '0) |=> (result == $past(data_a))); // R7
endmodule

bind rvs_shifter rvs_checker #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/rvs_shifter_test.sv
`timescale 1ns/1ps
module rvs_shifter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   size_code = 2'b00;
    logic         is_unsigned = 1'b0;
    logic         wide = 1'b1;
    logic [127:0] data_a = '0;
    logic [127:0] shift_b = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R10";
    string exp_tag = "R10";
    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;

    always #10 clk = ~clk;

    rvs_shifter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
        .is_unsigned(is_unsigned), .wide(wide), .data_a(data_a),
        .shift_b(shift_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] wmask(int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_lane(logic [63:0] x, int w, logic [7:0] c, bit uns);
        logic signed [129:0] v;
        logic signed [129:0] r;
        int s;
        s = int'($signed(c));
        v = 130'(x);
        if (!uns && x[w-1]) v = v - (130'sd1 <<< w);
        if (s >= 0) r = v <<< s;
        else        r = (v + (130'sd1 <<< (-s - 1))) >>> (-s);
        return r[63:0] & wmask(w);
    endfunction

    function automatic logic [127:0] ref_vec(logic [1:0] sz, bit uns, bit wd,
                                             logic [127:0] a, logic [127:0] b);
        int w;
        int nl;
        logic [127:0] acc;
        logic [63:0] x;
        logic [7:0] c;
        w = 8 << sz;
        nl = (wd ? 128 : 64) / w;
        acc = '0;
        for (int i = 0; i < nl; i++) begin
            x = 64'(a >> (i * w)) & wmask(w);
            c = 8'(b >> (i * w));
            acc = acc | (128'(ref_lane(x, w, c, uns)) << (i * w));
        end
        return acc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_res = '0;
        end else begin
            exp_valid = in_valid;
            if (in_valid) begin
                exp_res = ref_vec(size_code, is_unsigned, wide, data_a, shift_b);
                exp_tag = cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL R10 out_valid got %0b exp %0b", out_valid, exp_valid);
            end
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result got %h exp %h", exp_tag, result, exp_res);
            end
        end
    end

    task automatic shot(string tag, logic [1:0] sz, bit uns, bit wd,
                        logic [127:0] a, logic [127:0] b, bit chk, logic [127:0] expv);
        @(negedge clk);
        size_code = sz; is_unsigned = uns; wide = wd;
        data_a = a; shift_b = b; in_valid = 1'b1; cur_tag = tag;
        @(negedge clk);
        in_valid = 1'b0;
        if (chk) begin
            checks++;
            if (result !== expv) begin
                errors++;
                $display("FAIL %s direct got %h exp %h", tag, result, expv);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R11
        if (out_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R11 reset got %0b/%h exp 0/0", out_valid, result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        shot("R1", 2'b01, 0, 1, {8{16'h0123}}, {8{16'h7F01}}, 1, {8{16'h0246}});
        shot("R2", 2'b00, 1, 1, {16{8'hF3}}, {16{8'h03}}, 1, {16{8'h98}});
        shot("R3", 2'b00, 0, 1, {16{8'hFF}}, {16{8'h08}}, 1, '0);
        shot("R3", 2'b10, 1, 1, {4{32'hFFFF_FFFF}}, {4{32'h0000_007F}}, 1, '0);
        shot("R4", 2'b00, 0, 1, {16{8'h05}}, {16{8'hFF}}, 1, {16{8'h03}});
        shot("R4", 2'b10, 1, 1, {4{32'hFFFF_FFFF}}, {4{32'h0000_00FF}}, 1, {4{32'h8000_0000}});
        shot("R5", 2'b00, 0, 1, {16{8'hFB}}, {16{8'hFF}}, 1, {16{8'hFE}});
        shot("R5", 2'b00, 1, 1, {16{8'hFB}}, {16{8'hFF}}, 1, {16{8'h7E}});
        shot("R6", 2'b00, 1, 1, {16{8'h80}}, {16{8'hF8}}, 1, {16{8'h01}});
        shot("R6", 2'b00, 0, 1, {16{8'h80}}, {16{8'hF8}}, 1, '0);
        shot("R6", 2'b00, 1, 1, {16{8'hFF}}, {16{8'hF7}}, 1, '0);
        shot("R6", 2'b11, 1, 1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h80}}, 1, '0);
        shot("R7", 2'b10, 0, 1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, '0, 1,
             128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        shot("R8", 2'b11, 0, 1, {2{64'h3}}, {2{64'hFFFF_FFFF_FFFF_FF02}}, 1, {2{64'hC}});
        shot("R9", 2'b11, 0, 0, {64'hDEAD_BEEF_DEAD_BEEF, 64'h11},
             {64'h0101_0101_0101_0101, 64'h0}, 1, {64'h0, 64'h11});

        // R10: back-to-back strobes then a held result across idle cycles
        @(negedge clk);
        size_code = 2'b01; is_unsigned = 1; wide = 1; cur_tag = "R10";
        data_a = {8{16'h8001}}; shift_b = {8{16'h0001}}; in_valid = 1'b1;
        @(negedge clk);
        shift_b = {8{16'h00FF}};
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R11: reset in mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R11 mid reset got %0b/%h exp 0/0", out_valid, result);
        end
        rst_n = 1'b1;

        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            size_code = 2'($urandom_range(0, 3));
            is_unsigned = 1'($urandom);
            wide = 1'($urandom);
            data_a = {$urandom, $urandom, $urandom, $urandom};
            shift_b = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 1) == 0) begin
                for (int j = 0; j < 16; j++)
                    shift_b[j*8 +: 8] = 8'($signed($urandom_range(0, 140)) - 70);
            end
            cur_tag = "R2 R4 R5 R8";
            in_valid = ($urandom_range(0, 9) < 7);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule